// File: doc/BRIEF.md
# Multi-Type Interrupt Request Dispatcher

This block turns a raise request into one interrupt of one of three kinds. A request comes either from the command engine or from a direct raise command. Each request carries a two-bit kind code and a vector number. The block checks that the vector is legal for the kind. It then drives a level legacy line, issues an MSI message request, or issues an MSI-X message request. Building the message address and data is left to the logic downstream.

Each message output has a single valid/ready handshake. The valid signal and the vector stay fixed until ready is seen. While a message is outstanding the block reports itself busy and drops new requests. A request that names a reserved kind, or a vector outside the legal range for its kind, raises nothing. It produces a one-cycle error pulse instead. A status flag shows whether the most recent accepted request ended with an interrupt raised.

Top module: `irq_dispatch`

## Requirements
- R1: The kind code `kind_i` selects the scheme: 0 legacy, 1 MSI, 2 MSI-X, 3 reserved. A request is accepted on a rising edge where `eng_req_i` or `cmd_req_i` is high and `busy_o` is low.
- R2: A legacy request is legal only with vector 0. In the cycle after it is accepted, `intx_o` is high, `raised_o` is high and `done_o` pulses for one cycle.
- R3: An MSI request is legal for vectors 1 through 32. In the cycle after it is accepted, `msi_valid_o` is high and `msi_vec_o` (6 bits) carries the vector.
- R4: An MSI-X request is legal for vectors 1 through 2048, carried on a 12-bit field. In the cycle after it is accepted, `msix_valid_o` is high and `msix_vec_o` carries the vector.
- R5: Kind 3, or a vector outside the legal range for its kind, makes `err_o` pulse for exactly one cycle after acceptance. It drives no interrupt output and leaves `raised_o` low.
- R6: While a message valid is high and its ready is low, the valid and the vector hold steady. On the edge where valid and ready are both high, valid drops, and in the following cycle `raised_o` is high and `done_o` pulses.
- R7: `busy_o` is high exactly while a message valid is high. A request seen while busy is dropped: no error, no output change, nothing queued.
- R8: `intx_o` stays high until an edge with `intx_clr_i` high. If a clear and an accepted legal legacy request fall on the same edge, `intx_o` stays high.
- R9: `raised_o` goes low on every accepted request that does not complete at once. It goes high on a successful completion and otherwise holds its value.
- R10: `eng_req_i` and `cmd_req_i` high in the same cycle count as a single request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| eng_req_i | input | 1 | Raise request from the command engine |
| cmd_req_i | input | 1 | Direct raise command |
| kind_i | input | 2 | Interrupt kind code |
| vec_i | input | 12 | Requested vector number |
| busy_o | output | 1 | Message outstanding; requests are dropped |
| done_o | output | 1 | One-cycle pulse on a successful raise |
| err_o | output | 1 | One-cycle pulse on a rejected request |
| raised_o | output | 1 | Interrupt-raised status flag |
| intx_o | output | 1 | Level legacy interrupt line |
| intx_clr_i | input | 1 | Strobe that drops the legacy line |
| msi_valid_o | output | 1 | MSI message request valid |
| msi_vec_o | output | 6 | MSI vector |
| msi_ready_i | input | 1 | MSI message accepted |
| msix_valid_o | output | 1 | MSI-X message request valid |
| msix_vec_o | output | 12 | MSI-X vector |
| msix_ready_i | input | 1 | MSI-X message accepted |

## Verification
The clear strobe for the legacy line and a fresh legacy raise can reach the same flop on the same edge. The bench drives both on one negative edge while the line is already high. It then expects the line still high and a completion pulse, and only a later lone clear drops the line. A second overlap is a new request arriving while a message waits for ready. Here the bench looks for no error pulse, no second valid and an unchanged vector until the handshake ends.

// File: rtl/irq_dispatch_pkg.sv
package irq_dispatch_pkg;
  typedef enum logic [1:0] {
    KIND_LEGACY = 2'd0,
    KIND_MSI    = 2'd1,
    KIND_MSIX   = 2'd2,
    KIND_RSVD   = 2'd3
  } irq_kind_e;
endpackage

// File: rtl/irq_range_chk.sv
module irq_range_chk
  import irq_dispatch_pkg::*;
#(
  parameter int VEC_W    = 12,
  parameter int MSI_MAX  = 32,
  parameter int MSIX_MAX = 2048
) (
  input  irq_kind_e          kind_i,
  input  logic [VEC_W-1:0]   vec_i,
  output logic               ok_o,
  output logic               is_legacy_o,
  output logic               is_msi_o,
  output logic               is_msix_o
);
  localparam logic [VEC_W-1:0] MsiTop  = VEC_W'(MSI_MAX);
  localparam logic [VEC_W-1:0] MsixTop = VEC_W'(MSIX_MAX);

  logic nonzero;
  assign nonzero = |vec_i;

  always_comb begin
    is_legacy_o = 1'b0;
    is_msi_o    = 1'b0;
    is_msix_o   = 1'b0;
    ok_o        = 1'b0;
    unique case (kind_i)
      KIND_LEGACY: begin
        is_legacy_o = 1'b1;
        ok_o        = !nonzero;
      end
      KIND_MSI: begin
        is_msi_o = 1'b1;
        ok_o     = nonzero && (vec_i <= MsiTop);
      end
      KIND_MSIX: begin
        is_msix_o = 1'b1;
        ok_o      = nonzero && (vec_i <= MsixTop);
      end
      default: ok_o = 1'b0;
    endcase
  end

  // R1
  kind_onehot_chk: assert final ($onehot0({is_legacy_o, is_msi_o, is_msix_o}));
endmodule

// File: rtl/irq_msg_port.sv
module irq_msg_port #(
  parameter int W = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] vec_i,
  input  logic         ready_i,
  output logic         valid_o,
  output logic [W-1:0] vec_o,
  output logic         fire_o
);
  assign fire_o = valid_o && ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      vec_o   <= '0;
    end else if (fire_o) begin
      valid_o <= 1'b0;
    end else if (load_i && !valid_o) begin
      valid_o <= 1'b1;
      vec_o   <= vec_i;
    end
  end

  // R6
  hold_steady_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !ready_i |=> valid_o && $stable(vec_o));

  // R6
  drop_after_fire_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_o |=> !valid_o);
endmodule

// File: rtl/irq_intx_line.sv
module irq_intx_line (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic line_o
);
  // set wins over a simultaneous clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     line_o <= 1'b0;
    else if (set_i)  line_o <= 1'b1;
    else if (clr_i)  line_o <= 1'b0;
  end

  // R8
  fall_needs_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(line_o) |-> $past(clr_i) && !$past(set_i));

  // R8
  set_beats_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i && clr_i |=> line_o);
endmodule

// File: rtl/irq_dispatch.sv
module irq_dispatch
  import irq_dispatch_pkg::*;
#(
  parameter int VEC_W    = 12,
  parameter int MSI_MAX  = 32,
  parameter int MSIX_MAX = 2048,
  localparam int MSI_W   = $clog2(MSI_MAX + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             eng_req_i,
  input  logic             cmd_req_i,
  input  logic [1:0]       kind_i,
  input  logic [VEC_W-1:0] vec_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             err_o,
  output logic             raised_o,
  output logic             intx_o,
  input  logic             intx_clr_i,
  output logic             msi_valid_o,
  output logic [MSI_W-1:0] msi_vec_o,
  input  logic             msi_ready_i,
  output logic             msix_valid_o,
  output logic [VEC_W-1:0] msix_vec_o,
  input  logic             msix_ready_i
);
  logic req, accept, ok, is_legacy, is_msi, is_msix;
  logic msi_fire, msix_fire, legacy_go;
  logic done_q, err_q, raised_q;

  assign busy_o = msi_valid_o || msix_valid_o;
  assign req    = eng_req_i || cmd_req_i;
  assign accept = req && !busy_o;

  irq_range_chk #(
    .VEC_W   (VEC_W),
    .MSI_MAX (MSI_MAX),
    .MSIX_MAX(MSIX_MAX)
  ) u_range (
    .kind_i     (irq_kind_e'(kind_i)),
    .vec_i      (vec_i),
    .ok_o       (ok),
    .is_legacy_o(is_legacy),
    .is_msi_o   (is_msi),
    .is_msix_o  (is_msix)
  );

  assign legacy_go = accept && ok && is_legacy;

  irq_intx_line u_intx (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (legacy_go),
    .clr_i (intx_clr_i),
    .line_o(intx_o)
  );

  irq_msg_port #(.W(MSI_W)) u_msi (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (accept && ok && is_msi),
    .vec_i  (vec_i[MSI_W-1:0]),
    .ready_i(msi_ready_i),
    .valid_o(msi_valid_o),
    .vec_o  (msi_vec_o),
    .fire_o (msi_fire)
  );

  irq_msg_port #(.W(VEC_W)) u_msix (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (accept && ok && is_msix),
    .vec_i  (vec_i),
    .ready_i(msix_ready_i),
    .valid_o(msix_valid_o),
    .vec_o  (msix_vec_o),
    .fire_o (msix_fire)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q   <= 1'b0;
      err_q    <= 1'b0;
      raised_q <= 1'b0;
    end else begin
      done_q <= legacy_go || msi_fire || msix_fire;
      err_q  <= accept && !ok;
      if (accept)                      raised_q <= legacy_go;
      else if (msi_fire || msix_fire)  raised_q <= 1'b1;
    end
  end

  assign done_o   = done_q;
  assign err_o    = err_q;
  assign raised_o = raised_q;

  // R7
  one_msg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(msi_valid_o && msix_valid_o));

  // R5
  err_no_raise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !raised_o && !done_o && !busy_o);

  // R9
  done_sets_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> raised_o);

  // R7
  busy_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && req |=> !err_o);

  // R3
  msi_vec_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msi_valid_o |-> (msi_vec_o != '0) && (int'(msi_vec_o) <= MSI_MAX));

  // R4
  msix_vec_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msix_valid_o |-> (msix_vec_o != '0) && (int'(msix_vec_o) <= MSIX_MAX));
endmodule

// File: tb/irq_dispatch_tb_top.sv
module irq_dispatch_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic eng_req = 1'b0, cmd_req = 1'b0;
  logic [1:0] kind = '0;
  logic [11:0] vec = '0;
  logic intx_clr = 1'b0, msi_ready = 1'b0, msix_ready = 1'b0;
  logic busy, done, err, raised, intx, msi_valid, msix_valid;
  logic [5:0] msi_vec;
  logic [11:0] msix_vec;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  irq_dispatch dut_i (
    .clk_i(clk), .rst_ni(rst_n), .eng_req_i(eng_req), .cmd_req_i(cmd_req),
    .kind_i(kind), .vec_i(vec), .busy_o(busy), .done_o(done), .err_o(err),
    .raised_o(raised), .intx_o(intx), .intx_clr_i(intx_clr),
    .msi_valid_o(msi_valid), .msi_vec_o(msi_vec), .msi_ready_i(msi_ready),
    .msix_valid_o(msix_valid), .msix_vec_o(msix_vec), .msix_ready_i(msix_ready)
  );

  task automatic chk(input bit cond, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!cond) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic eq(input string req, input string what, input int act, input int exp);
    chk(act == exp, req, what, act, exp);
  endtask

  // called at a negedge; returns at the negedge after the accept edge
  task automatic raise(input bit e, input bit c, input logic [1:0] k, input logic [11:0] v);
    eng_req = e; cmd_req = c; kind = k; vec = v;
    @(negedge clk);
    eng_req = 1'b0; cmd_req = 1'b0;
  endtask

  task automatic t_reset();
    eq("R1", "busy after reset", busy, 0);
    eq("R9", "raised after reset", raised, 0);
    eq("R2", "intx after reset", intx, 0);
    eq("R3", "msi_valid after reset", msi_valid, 0);
    eq("R4", "msix_valid after reset", msix_valid, 0);
    eq("R5", "err after reset", err, 0);
  endtask

  task automatic t_legacy();
    raise(1, 0, 2'd0, 12'd0);
    eq("R2", "intx up", intx, 1);
    eq("R2", "done pulse", done, 1);
    eq("R2", "raised set", raised, 1);
    @(negedge clk);
    eq("R2", "done one cycle", done, 0);
    eq("R8", "intx held", intx, 1);
    intx_clr = 1'b1;
    @(negedge clk);
    intx_clr = 1'b0;
    eq("R8", "intx cleared", intx, 0);
    eq("R9", "raised holds", raised, 1);
  endtask

  task automatic t_bad(input logic [1:0] k, input logic [11:0] v, input string req);
    raise(0, 1, k, v);
    eq(req, "err pulse", err, 1);
    eq("R5", "raised low on reject", raised, 0);
    eq("R5", "no output", {intx, msi_valid, msix_valid}, 0);
    @(negedge clk);
    eq("R5", "err one cycle", err, 0);
  endtask

  task automatic t_msi_wait();
    raise(1, 0, 2'd1, 12'd32);
    eq("R3", "msi valid", msi_valid, 1);
    eq("R3", "msi vec 32", msi_vec, 32);
    eq("R7", "busy", busy, 1);
    eq("R9", "raised cleared on accept", raised, 0);
    repeat (3) @(negedge clk);
    eq("R6", "valid held", msi_valid, 1);
    eq("R6", "vec held", msi_vec, 32);
    raise(0, 1, 2'd2, 12'd5);
    eq("R7", "dropped: no msix", msix_valid, 0);
    eq("R7", "dropped: no err", err, 0);
    eq("R7", "dropped: vec kept", msi_vec, 32);
    msi_ready = 1'b1;
    @(negedge clk);
    msi_ready = 1'b0;
    eq("R6", "valid drops", msi_valid, 0);
    eq("R6", "done after handshake", done, 1);
    eq("R6", "raised after handshake", raised, 1);
    eq("R7", "not busy", busy, 0);
    @(negedge clk);
    eq("R7", "nothing queued", msix_valid, 0);
  endtask

  task automatic t_msi_low();
    msi_ready = 1'b1;
    raise(1, 0, 2'd1, 12'd1);
    eq("R3", "msi vec 1", msi_vec, 1);
    eq("R3", "msi valid", msi_valid, 1);
    @(negedge clk);
    msi_ready = 1'b0;
    eq("R6", "immediate handshake", msi_valid, 0);
    eq("R6", "done", done, 1);
  endtask

  task automatic t_msix();
    raise(0, 1, 2'd2, 12'd2048);
    eq("R4", "msix valid", msix_valid, 1);
    eq("R4", "msix vec 2048", msix_vec, 2048);
    eq("R4", "msi idle", msi_valid, 0);
    @(negedge clk);
    msix_ready = 1'b1;
    @(negedge clk);
    msix_ready = 1'b0;
    eq("R4", "msix done", done, 1);
    eq("R4", "msix raised", raised, 1);
  endtask

  task automatic t_overlap();
    raise(1, 0, 2'd0, 12'd0);
    eq("R8", "intx up", intx, 1);
    intx_clr = 1'b1;
    raise(0, 1, 2'd0, 12'd0);
    intx_clr = 1'b0;
    eq("R8", "set beats clear", intx, 1);
    eq("R8", "done on overlap", done, 1);
    intx_clr = 1'b1;
    @(negedge clk);
    intx_clr = 1'b0;
    eq("R8", "lone clear", intx, 0);
  endtask

  task automatic t_both_src();
    raise(1, 1, 2'd1, 12'd7);
    eq("R10", "single msi vec 7", msi_vec, 7);
    eq("R10", "no err", err, 0);
    msi_ready = 1'b1;
    @(negedge clk);
    msi_ready = 1'b0;
    eq("R10", "done once", done, 1);
    @(negedge clk);
    eq("R10", "no second done", done, 0);
    eq("R10", "no second valid", msi_valid, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_legacy();
    t_bad(2'd0, 12'd1, "R2");
    t_msi_wait();
    t_bad(2'd1, 12'd0, "R3");
    t_bad(2'd1, 12'd33, "R3");
    t_msi_low();
    t_msix();
    t_bad(2'd2, 12'd2049, "R4");
    t_bad(2'd2, 12'd0, "R4");
    t_bad(2'd3, 12'd1, "R1");
    t_overlap();
    t_both_src();
    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=1 expected=0");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule